// File: doc/BRIEF.md
# Multi-address I2C register slave

This block is an I2C target that sits on a two-wire bus and turns bus transactions into accesses on a simple register port toward on-chip logic. Both bus lines are brought into the core clock domain through synchronizers and sampled there. START and STOP conditions are detected from the synchronized lines, and the block drives SDA only by pulling it low through an output-enable.

The block answers to a window of consecutive 7-bit device addresses. A mode input selects how wide that window is. With the mode input low, two addresses are accepted. With the mode input high, four addresses are accepted: the two base ones plus the next two. All accepted addresses reach the same register file.

The first data byte of a write transaction loads an internal register pointer, and any bytes after it are written to the registers. A read returns bytes starting at the pointer. The read may follow a repeated START, or it may start a new transaction and continue from wherever the pointer was left. The pointer advances by one after every data byte that moves in either direction. As a result, word reads and longer sequential reads step through consecutive registers, and the byte at the lower address goes out first.

Top module: `i2c_multi_slave`

## Requirements
- R1: After reset the block does not drive SDA (`sda_oe` low) and does not write the register port (`reg_we` low).
- R2: With `priv_mode_i` low the block acknowledges the address bytes A0h and A2h (7-bit 50h and 51h, R/W in bit 0) and gives no acknowledge to A4h or A6h.
- R3: With `priv_mode_i` high the block additionally acknowledges A4h and A6h. Such an address gives full access to the same registers, and A8h (7-bit 54h) is never acknowledged.
- R4: A write transaction consists of an address byte with R/W = 0, a pointer byte and a data byte. The block acknowledges each of these bytes and writes the data byte to the register at the pointer.
- R5: A pointer write, then a repeated START, then an address byte with R/W = 1 makes the block shift out the register at the pointer.
- R6: A two-byte read returns the register at pointer p first as the high-order byte, and then the register at p+1 as the low-order byte.
- R7: The block keeps sending bytes while the master acknowledges. After a NACK it releases SDA and stays off the bus until the next START, so a further clocked byte reads FFh.
- R8: The pointer advances by one after each data byte, whether written or read. Multi-byte writes therefore fill consecutive registers, and a later read without a pointer byte continues at the next register.
- R9: An address byte that matches no accepted address is not acknowledged. The bytes that follow it before the next START receive no acknowledge and cause no register write.
- R10: A STOP received in the middle of a byte ends the transaction with no write. A START received in the middle of a byte discards the partial byte and begins a new address phase with the pointer unchanged.
- R11: The block changes SDA only while SCL is low, and bytes move MSB first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| priv_mode_i | input | 1 | High widens the accepted address window from two to four addresses |
| sda_oe | output | 1 | High pulls SDA low; low releases the line |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write at `reg_addr` |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file contents at `reg_addr`, combinational |

## Verification
The bench builds the block with its default parameters: base address 50h, two slots in user mode, four slots in privileged mode and two synchronizer stages. These values place both edges of each address window within reach: 51h/52h is the boundary in user mode and 53h/54h is the boundary in privileged mode. Each bus quarter-bit lasts ten core clocks, which leaves room for the synchronizer delay and still lets a START or a STOP land in the middle of a byte. The register file behind the port starts with a fixed pattern, so writes, reads that should not happen, and pointer drift all show up as wrong byte values.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } kind_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_last_q, sda_last_q;
  logic              scl_s;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_last_q <= scl_s;
      sda_last_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_last_q;
  assign scl_fall  = ~scl_s & scl_last_q;
  assign start_det = scl_s & scl_last_q & sda_last_q & ~sda_s;
  assign stop_det  = scl_s & scl_last_q & ~sda_last_q & sda_s;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
  parameter int DEV_BASE = 'h50,
  parameter int N_USER   = 2,
  parameter int N_PRIV   = 4
) (
  input  logic [6:0] cand,
  input  logic       priv,
  output logic       hit
);

  logic [N_PRIV-1:0] slot_hit;

  for (genvar k = 0; k < N_PRIV; k++) begin : g_slot
    localparam logic [6:0] SLOT = 7'(DEV_BASE + k);
    if (k < N_USER) begin : g_user
      assign slot_hit[k] = (cand == SLOT);
    end else begin : g_priv
      assign slot_hit[k] = priv & (cand == SLOT);
    end
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_hit,
  output logic [6:0]        addr_cand,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);

  state_t             st_q, st_d;
  kind_t              kind_q, kind_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  ptr_q, ptr_d;
  logic               rw_q, rw_d;
  logic               nack_q, nack_d;
  logic               oe_q, oe_d;
  logic               we;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    nack_d = nack_q;
    oe_d   = oe_q;
    we     = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_RX;
      kind_d = K_ADDR;
      cnt_d  = '0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            case (kind_q)
              K_ADDR: begin
                if (addr_hit) begin
                  rw_d = sh_q[0];
                  oe_d = 1'b1;
                  st_d = ST_RACK;
                end else begin
                  st_d = ST_IGNORE;
                end
              end
              K_PTR: begin
                ptr_d = sh_q;
                oe_d  = 1'b1;
                st_d  = ST_RACK;
              end
              default: begin
                we    = 1'b1;
                ptr_d = ptr_q + 8'd1;
                oe_d  = 1'b1;
                st_d  = ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == K_ADDR && rw_q) begin
              sh_d  = reg_rdata;
              ptr_d = ptr_q + 8'd1;
              oe_d  = ~reg_rdata[BYTE_W-1];
              st_d  = ST_TX;
            end else begin
              oe_d   = 1'b0;
              st_d   = ST_RX;
              kind_d = (kind_q == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              oe_d = 1'b0;
              st_d = ST_MACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              sh_d  = reg_rdata;
              ptr_d = ptr_q + 8'd1;
              oe_d  = ~reg_rdata[BYTE_W-1];
              cnt_d = '0;
              st_d  = ST_TX;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      nack_q <= nack_d;
      oe_q   <= oe_d;
    end
  end

  assign addr_cand = sh_q[BYTE_W-1:1];
  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
  assign reg_we    = we;

endmodule

// File: rtl/i2c_multi_slave.sv
module i2c_multi_slave #(
  parameter int DEV_BASE    = 'h50,
  parameter int N_USER      = 2,
  parameter int N_PRIV      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       priv_mode_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       addr_hit;
  logic [6:0] addr_cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_addr_match #(.DEV_BASE(DEV_BASE), .N_USER(N_USER), .N_PRIV(N_PRIV)) u_match (
    .cand(addr_cand), .priv(priv_mode_i), .hit(addr_hit)
  );

  i2cs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_hit(addr_hit), .addr_cand(addr_cand), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int DEV_BASE = 'h50,
  parameter int N_USER   = 2,
  parameter int N_PRIV   = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_we,
  input logic       start_det,
  input logic       stop_det,
  input logic       addr_hit,
  input logic [6:0] addr_cand,
  input logic       priv
);

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);  // R11

  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);  // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);  // R10

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);  // R10

  AST_USER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && !priv) |->
      (int'(addr_cand) >= DEV_BASE && int'(addr_cand) < DEV_BASE + N_USER));  // R2

  AST_PRIV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |->
      (int'(addr_cand) >= DEV_BASE && int'(addr_cand) < DEV_BASE + N_PRIV));  // R3

endmodule

bind i2c_multi_slave i2cs_checker #(
  .DEV_BASE(DEV_BASE), .N_USER(N_USER), .N_PRIV(N_PRIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .start_det(start_det), .stop_det(stop_det),
  .addr_hit(addr_hit), .addr_cand(addr_cand), .priv(priv_mode_i)
);

// File: tb/i2c_multi_slave_bench.sv
`timescale 1ns/1ps
module i2c_multi_slave_bench;

  localparam int QCYC = 10;
  localparam int WD   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       priv = 1'b0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;
  logic [7:0] mem [256];

  int n_checks = 0;
  int n_fail   = 0;
  int oe_viol  = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_multi_slave u_i2c_multi_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .priv_mode_i(priv), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitq;
    repeat (QCYC) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; waitq;
    scl_m = 1'b1; waitq;
    sda_m = 1'b0; waitq;
    scl_m = 1'b0; waitq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; waitq;
    scl_m = 1'b1; waitq;
    sda_m = 1'b1; waitq;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; waitq;
    scl_m = 1'b1; waitq;
    waitq;
    scl_m = 1'b0; waitq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; waitq;
    scl_m = 1'b1; waitq;
    ack = ~sda_line; waitq;
    scl_m = 1'b0; waitq;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; waitq;
      scl_m = 1'b1; waitq;
      b = {b[6:0], sda_line}; waitq;
      scl_m = 1'b0; waitq;
    end
    put_bit(nack);
  endtask

  task automatic write_regs(input logic [7:0] dev, input logic [7:0] ptr,
                            input logic [7:0] d0, input int nbytes, input string req);
    logic ack;
    bus_start;
    send_byte(dev, ack);  check(req, "addr ack", int'(ack), 1);
    send_byte(ptr, ack);  check(req, "ptr ack", int'(ack), 1);
    for (int i = 0; i < nbytes; i++) begin
      send_byte(d0 + 8'(i * 'h11), ack); check(req, "data ack", int'(ack), 1);
    end
    bus_stop;
  endtask

  task automatic point_then_read(input logic [7:0] dev, input logic [7:0] ptr);
    logic ack;
    bus_start;
    send_byte(dev, ack);
    send_byte(ptr, ack);
    bus_start;
    send_byte(dev | 8'h01, ack);
    check("R5", "read addr ack", int'(ack), 1);
  endtask

  localparam logic [9:0] ADDR_VEC [11] = '{
    {1'b0, 8'hA0, 1'b1}, {1'b0, 8'hA2, 1'b1}, {1'b0, 8'hA4, 1'b0},
    {1'b0, 8'hA6, 1'b0}, {1'b1, 8'hA0, 1'b1}, {1'b1, 8'hA2, 1'b1},
    {1'b1, 8'hA4, 1'b1}, {1'b1, 8'hA6, 1'b1}, {1'b1, 8'hA8, 1'b0},
    {1'b0, 8'h20, 1'b0}, {1'b1, 8'h9E, 1'b0}
  };

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run;
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "sda_oe after reset", int'(sda_oe), 0);
    check("R1", "reg_we after reset", int'(reg_we), 0);

    // R2 R3 R9: address window per mode
    for (int v = 0; v < 11; v++) begin
      priv = ADDR_VEC[v][9];
      bus_start;
      send_byte(ADDR_VEC[v][8:1], ack);
      check(ADDR_VEC[v][9] ? "R3" : "R2", $sformatf("ack for %0h", ADDR_VEC[v][8:1]),
            int'(ack), int'(ADDR_VEC[v][0]));
      bus_stop;
    end

    priv = 1'b0;
    // R4: byte write
    write_regs(8'hA0, 8'h10, 8'h5A, 1, "R4");
    check("R4", "mem[10]", int'(mem[8'h10]), 'h5A);
    // R8: multi-byte write fills consecutive registers
    write_regs(8'hA2, 8'h20, 8'h11, 3, "R8");
    check("R8", "mem[20]", int'(mem[8'h20]), 'h11);
    check("R8", "mem[21]", int'(mem[8'h21]), 'h22);
    check("R8", "mem[22]", int'(mem[8'h22]), 'h33);

    // R5 R11: byte read through repeated START, MSB first
    point_then_read(8'hA0, 8'h10);
    recv_byte(1'b1, b); bus_stop;
    check("R11", "byte read 10", int'(b), 'h5A);
    point_then_read(8'hA0, 8'h21);
    recv_byte(1'b1, b); bus_stop;
    check("R5", "byte read 21", int'(b), 'h22);

    // R6: word read, high byte first
    point_then_read(8'hA2, 8'h30);
    recv_byte(1'b0, b); check("R6", "word high", int'(b), int'(pat(8'h30)));
    recv_byte(1'b1, b); check("R6", "word low", int'(b), int'(pat(8'h31)));
    bus_stop;

    // R7: sequential read and bus release after NACK
    point_then_read(8'hA0, 8'h40);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i == 3, b);
      check("R7", $sformatf("seq byte %0d", i), int'(b), int'(pat(8'h40 + 8'(i))));
    end
    recv_byte(1'b1, b);
    check("R7", "after nack", int'(b), 'hFF);
    bus_stop;
    // R8: read without pointer continues at next register
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b1, b); bus_stop;
    check("R8", "continued read", int'(b), int'(pat(8'h44)));

    // R9: unmatched address, following bytes ignored
    bus_start;
    send_byte(8'hA4, ack); check("R9", "no ack A4 user", int'(ack), 0);
    send_byte(8'h60, ack); check("R9", "no ack ptr", int'(ack), 0);
    send_byte(8'h99, ack); check("R9", "no ack data", int'(ack), 0);
    bus_stop;
    check("R9", "mem[60] untouched", int'(mem[8'h60]), int'(pat(8'h60)));
    check("R9", "mem[99] untouched", int'(mem[8'h99]), int'(pat(8'h99)));

    // R3: privileged address writes and reads the same registers
    priv = 1'b1;
    write_regs(8'hA6, 8'h70, 8'hC3, 1, "R3");
    check("R3", "mem[70]", int'(mem[8'h70]), 'hC3);
    point_then_read(8'hA4, 8'h70);
    recv_byte(1'b1, b); bus_stop;
    check("R3", "read via A5", int'(b), 'hC3);
    priv = 1'b0;

    // R10: STOP in the middle of a data byte
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h50, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop;
    check("R10", "mem[50] after stop", int'(mem[8'h50]), int'(pat(8'h50)));
    // R10: START in the middle of a data byte
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h51, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start;
    send_byte(8'hA1, ack);
    check("R10", "ack after mid start", int'(ack), 1);
    recv_byte(1'b1, b); bus_stop;
    check("R10", "read after mid start", int'(b), int'(pat(8'h51)));
    check("R10", "mem[51] untouched", int'(mem[8'h51]), int'(pat(8'h51)));

    waitq;
    check("R11", "sda changes with scl high", oe_viol, 0);
    check("R1", "sda released at end", int'(sda_oe), 0);
    finish_run;
  end

endmodule